// File: doc/BRIEF.md
# Split-Exponent Digit-Pair Command Sequencer

This block drives an external modular arithmetic unit through a right-to-left exponentiation in which the signed-digit exponent is cut into a low half and a high half, and both halves are scanned at the same time. On each step it takes one digit from each half at the same position and reads the pair as a column. A column that is not zero names one of eight accumulators, and the block asks the arithmetic unit to multiply the running power into that accumulator. Every step ends with a request to square the running power.

After the last column, the block sends a fixed closing sequence. This sequence folds the eight accumulators into a low-half result and a high-half result. It raises the high-half result by squaring it once per column, and it multiplies the two results together. The arithmetic unit holds nine registers: accumulators 0 to 7, which the user loads with 1 before a run, and register 8, the running power, which the user loads with the base x. The block itself does no arithmetic. It only sends commands over a valid/ready stream. When the last command is accepted, the value x^e sits in register 4.

Top module: `hx_pair_dispatch`

## Requirements
- R1: While `rst_n` is low at a clock edge, `busy`, `done` and `cmd_valid` are all low after that edge. This also holds when reset falls in the middle of a run.
- R2: A `start` seen while idle latches `exp_digits` (digit j in bits 2j+1:2j). An odd digit count gets an implied zero digit on top, giving an even count L. The low half is digits 0..L/2-1 and the high half is digits L/2..L-1. A `start` seen while `busy` is high is ignored, and the run in progress keeps its original commands.
- R3: Digit codes are 2'b01 = +1 and 2'b11 = -1. Both 2'b00 and 2'b10 mean zero.
- R4: Step i (i = 0..L/2-1, in increasing order) pairs high digit L/2+i with low digit i. If the pair is not (0,0), the step first sends MUL dst=k src=8. The index k for each (high, low) pair is: (-1,-1)=0, (-1,0)=1, (-1,+1)=2, (0,-1)=3, (0,+1)=4, (+1,-1)=5, (+1,0)=6, (+1,+1)=7. Every step then sends SQR dst=8 src=8. A (0,0) pair sends only the SQR.
- R5: After the scan, the closing sequence is exactly MUL 3,0; MUL 3,5; MUL 1,0; MUL 1,2; MUL 4,2; MUL 4,7; MUL 6,5; MUL 6,7; INV 3,3; INV 1,1; MUL 4,3; MUL 6,1; then L/2 times SQR 6,6; then MUL 4,6.
- R6: Opcode values are MUL=2'b01 (dst ← dst·src), SQR=2'b10 (dst ← src²) and INV=2'b11 (dst ← src⁻¹). If the registers start as described above, applying all accepted commands in order leaves x^e in register 4, where e = Σ dⱼ·2ʲ.
- R7: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. While `cmd_ready` is low, `cmd_valid` stays high and `cmd_op`, `cmd_dst` and `cmd_src` do not change, and the scan does not advance.
- R8: `done` is high for exactly the one cycle after the final command is accepted. `busy` is low in that same cycle, and `cmd_valid` is never high while `busy` is low.
- R9: One run sends exactly N + L/2 + L/2 + 13 commands, where N is the number of nonzero columns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a run with the digits currently on `exp_digits` |
| exp_digits | input | 2*NDIG | Signed exponent, two bits per digit, digit 0 lowest |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse after the final command is accepted |
| cmd_valid | output | 1 | A command is offered |
| cmd_ready | input | 1 | The arithmetic unit takes the command on this edge |
| cmd_op | output | 2 | Opcode: MUL, SQR or INV |
| cmd_dst | output | 4 | Destination register index (0..8) |
| cmd_src | output | 4 | Source register index (0..8) |

## Verification
The bench builds the block with NDIG = 7. This exercises the implied zero digit at the top of the high half and gives four columns per run, which is short enough to check every command of every run. A modular arithmetic model in the bench carries out the command stream with base 3 modulo 65521. It compares the final register 4 with 3^e, so negative exponents and the closing sequence's inversions are checked end to end. Ready patterns that alternate and stall irregularly test the hold behaviour. The digit vectors include all-zero, all-plus, all-minus and 2'b10-coded exponents.

// File: rtl/hx_pkg.sv
// Shared types for the split-exponent command sequencer.
// Assumes an external unit with nine registers: 0..7 accumulators, 8 power.
package hx_pkg;
    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_MUL  = 2'b01,
        OP_SQR  = 2'b10,
        OP_INV  = 2'b11
    } op_e;

    localparam logic [3:0] REG_POW = 4'd8;
    localparam logic [3:0] REG_LO  = 4'd4;
    localparam logic [3:0] REG_HI  = 4'd6;

    typedef struct packed {
        op_e        op;
        logic [3:0] dst;
        logic [3:0] src;
    } cmd_t;
endpackage

// File: rtl/hx_pair_map.sv
// Maps a (high, low) signed-digit column to an accumulator index.
// Codes: 01 = +1, 11 = -1, 00 and 10 = 0. The index is the base-3
// column value with the all-zero column removed from the count.
module hx_pair_map (
    input  logic [1:0] hi_code,
    input  logic [1:0] lo_code,
    output logic       nonzero,
    output logic [2:0] acc_idx
);
    // Shift a digit code to the range 0..2 (-1 -> 0, 0 -> 1, +1 -> 2).
    function automatic logic [3:0] tern(input logic [1:0] c);
        case (c)
            2'b01:   tern = 4'd2;
            2'b11:   tern = 4'd0;
            default: tern = 4'd1;
        endcase
    endfunction

    logic [3:0] col;

    // Form the column value and drop the (0,0) slot at value 4.
    always_comb begin
        col     = tern(hi_code) * 4'd3 + tern(lo_code);
        nonzero = (col != 4'd4);
        acc_idx = (col < 4'd4) ? col[2:0] : 3'(col - 4'd1);
    end
endmodule

// File: rtl/hx_epilogue.sv
// Closing command list, indexed by position k. Folds the accumulators into
// the low result (reg 4) and the high result (reg 6), squares the high result
// HALF times, then multiplies it into reg 4. Assumes k < HALF + 13.
module hx_epilogue
    import hx_pkg::*;
#(
    parameter int HALF = 4,
    parameter int KW   = 5
) (
    input  logic [KW-1:0] k,
    output cmd_t          cmd,
    output logic          last
);
    // Fixed folding list, then the squaring run, then the final product.
    always_comb begin
        cmd = '{op: OP_MUL, dst: REG_LO, src: REG_HI};
        if (int'(k) < 12) begin
            case (int'(k))
                0:  cmd = '{op: OP_MUL, dst: 4'd3, src: 4'd0};
                1:  cmd = '{op: OP_MUL, dst: 4'd3, src: 4'd5};
                2:  cmd = '{op: OP_MUL, dst: 4'd1, src: 4'd0};
                3:  cmd = '{op: OP_MUL, dst: 4'd1, src: 4'd2};
                4:  cmd = '{op: OP_MUL, dst: 4'd4, src: 4'd2};
                5:  cmd = '{op: OP_MUL, dst: 4'd4, src: 4'd7};
                6:  cmd = '{op: OP_MUL, dst: 4'd6, src: 4'd5};
                7:  cmd = '{op: OP_MUL, dst: 4'd6, src: 4'd7};
                8:  cmd = '{op: OP_INV, dst: 4'd3, src: 4'd3};
                9:  cmd = '{op: OP_INV, dst: 4'd1, src: 4'd1};
                10: cmd = '{op: OP_MUL, dst: 4'd4, src: 4'd3};
                default: cmd = '{op: OP_MUL, dst: 4'd6, src: 4'd1};
            endcase
        end else if (int'(k) < 12 + HALF) begin
            cmd = '{op: OP_SQR, dst: REG_HI, src: REG_HI};
        end
        last = (int'(k) == 12 + HALF);
    end
endmodule

// File: rtl/hx_pair_dispatch.sv
// Top: latches a signed exponent on start and scans both halves column by
// column. It sends MUL into the column's accumulator for nonzero columns and
// SQR of the power each step, then the closing list. Assumes NDIG >= 3 and a
// sink that holds register contents between commands.
module hx_pair_dispatch
    import hx_pkg::*;
#(
    parameter int NDIG = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2*NDIG-1:0] exp_digits,
    output logic              busy,
    output logic              done,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [1:0]        cmd_op,
    output logic [3:0]        cmd_dst,
    output logic [3:0]        cmd_src
);
    localparam int PADL  = NDIG + (NDIG % 2);
    localparam int HALF  = PADL / 2;
    localparam int HW    = 2 * HALF;
    localparam int SW    = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int EPI_N = HALF + 13;
    localparam int KW    = $clog2(EPI_N);

    typedef enum logic [1:0] {ST_IDLE, ST_MUL, ST_SQR, ST_EPI} st_e;

    st_e             state;
    logic [HW-1:0]   lo_q, hi_q;
    logic [2*PADL-1:0] padded;
    logic [SW-1:0]   step, nsel;
    logic [KW-1:0]   k;
    logic [2:0]      mul_idx, nxt_idx;
    logic [1:0]      ent_lo, ent_hi;
    logic            nxt_nz, fire, step_last;
    cmd_t            epi_cmd, cur;
    logic            epi_last;

    // Zero-extend the exponent to an even digit count.
    always_comb begin
        padded = '0;
        padded[2*NDIG-1:0] = exp_digits;
    end

    // Column for the next step: the first column when idle, else step + 1.
    always_comb begin
        step_last = (step == SW'(HALF - 1));
        nsel      = step_last ? '0 : step + SW'(1);
        if (state == ST_IDLE) begin
            ent_lo = padded[1:0];
            ent_hi = padded[HW+1:HW];
        end else begin
            ent_lo = lo_q[2*int'(nsel) +: 2];
            ent_hi = hi_q[2*int'(nsel) +: 2];
        end
    end

    hx_pair_map u_map (
        .hi_code (ent_hi),
        .lo_code (ent_lo),
        .nonzero (nxt_nz),
        .acc_idx (nxt_idx)
    );

    hx_epilogue #(.HALF(HALF), .KW(KW)) u_epi (
        .k    (k),
        .cmd  (epi_cmd),
        .last (epi_last)
    );

    // Choose the command offered in the current state.
    always_comb begin
        cur = '{op: OP_NONE, dst: 4'd0, src: 4'd0};
        case (state)
            ST_MUL:  cur = '{op: OP_MUL, dst: {1'b0, mul_idx}, src: REG_POW};
            ST_SQR:  cur = '{op: OP_SQR, dst: REG_POW, src: REG_POW};
            ST_EPI:  cur = epi_cmd;
            default: cur = '{op: OP_NONE, dst: 4'd0, src: 4'd0};
        endcase
        cmd_valid = (state != ST_IDLE);
        cmd_op    = cur.op;
        cmd_dst   = cur.dst;
        cmd_src   = cur.src;
        busy      = (state != ST_IDLE);
        fire      = cmd_valid && cmd_ready;
    end

    // Sequencer: latch, scan the columns, send the closing list, pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            step    <= '0;
            k       <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
            mul_idx <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    lo_q    <= padded[HW-1:0];
                    hi_q    <= padded[2*PADL-1:HW];
                    step    <= '0;
                    mul_idx <= nxt_idx;
                    state   <= nxt_nz ? ST_MUL : ST_SQR;
                end
                ST_MUL: if (fire) state <= ST_SQR;
                ST_SQR: if (fire) begin
                    if (step_last) begin
                        state <= ST_EPI;
                        k     <= '0;
                    end else begin
                        step    <= nsel;
                        mul_idx <= nxt_idx;
                        state   <= nxt_nz ? ST_MUL : ST_SQR;
                    end
                end
                default: if (fire) begin
                    if (epi_last) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        k <= k + KW'(1);
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/hx_pair_dispatch_chk.sv
// Protocol checker bound to the sequencer: handshake hold, idle quietness,
// the done pulse, and the shape of each opcode's operands.
module hx_pair_dispatch_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic [1:0] cmd_op,
    input logic [3:0] cmd_dst,
    input logic [3:0] cmd_src
);
    p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op)
                                    && $stable(cmd_dst) && $stable(cmd_src));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cmd_valid);

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_reg_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> cmd_op != 2'b00 && cmd_dst <= 4'd8 && cmd_src <= 4'd8);

    p_sqr_self_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_op == 2'b10 |-> cmd_dst == cmd_src);

    p_inv_self_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_op == 2'b11 |-> cmd_dst == cmd_src && cmd_dst < 4'd8);
endmodule

bind hx_pair_dispatch hx_pair_dispatch_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_dst   (cmd_dst),
    .cmd_src   (cmd_src)
);

// File: tb/hx_pair_dispatch_tb_top.sv
// Bench: runs a vector table of exponents through the sequencer, compares the
// command stream with a model built from the requirements, and replays it on
// a modular register model. Then runs directed reset and busy-start cases.
module hx_pair_dispatch_tb_top;
    localparam int NDIG = 7;
    localparam int HALF = 4;
    localparam longint PM = 65521;
    localparam longint XB = 3;
    localparam int NV = 6;

    localparam logic [2*NDIG-1:0] VEC [NV] = '{
        14'b00_00_00_00_00_00_00,
        14'b01_01_01_01_01_01_01,
        14'b11_11_11_11_11_11_11,
        14'b11_01_00_11_01_10_01,
        14'b10_10_01_10_11_10_10,
        14'b01_00_11_00_01_00_11
    };
    localparam int RMODE [NV] = '{0, 1, 1, 0, 1, 1};

    localparam int EP_O [12] = '{1,1,1,1,1,1,1,1,3,3,1,1};
    localparam int EP_D [12] = '{3,3,1,1,4,4,6,6,3,1,4,6};
    localparam int EP_S [12] = '{0,5,0,2,2,7,5,7,3,1,3,1};

    logic clk, rst_n, start, cmd_ready;
    logic [2*NDIG-1:0] exp_digits;
    logic busy, done, cmd_valid;
    logic [1:0] cmd_op;
    logic [3:0] cmd_dst, cmd_src;

    int total, bad;
    logic [7:0] lf;

    hx_pair_dispatch #(.NDIG(NDIG)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .exp_digits(exp_digits),
        .busy(busy), .done(done), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_dst(cmd_dst), .cmd_src(cmd_src)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic int dval(input logic [2*NDIG-1:0] v, input int i);
        if (i >= NDIG) return 0;
        case (v[2*i +: 2])
            2'b01:   return 1;
            2'b11:   return -1;
            default: return 0;
        endcase
    endfunction

    // R4 accumulator table, written per (high, low) pair.
    function automatic int bidx(input int h, input int l);
        if (h < 0) return (l < 0) ? 0 : (l == 0) ? 1 : 2;
        if (h == 0) return (l < 0) ? 3 : 4;
        return (l < 0) ? 5 : (l == 0) ? 6 : 7;
    endfunction

    function automatic longint powmod(input longint b, input longint e);
        longint r = 1, bb = b % PM, ee = e;
        while (ee > 0) begin
            if (ee % 2 == 1) r = (r * bb) % PM;
            bb = (bb * bb) % PM;
            ee = ee / 2;
        end
        return r;
    endfunction

    task automatic run_vec(input logic [2*NDIG-1:0] v, input int rmode, input bit inject);
        int eo[64], ed[64], es[64];
        int n = 0, got = 0, cyc = 0, stall_err = 0, seq_err = 0, bad_at = -1;
        int act_o = 0, act_d = 0, act_s = 0;
        longint rf[9];
        longint ev = 0, em;
        bit pend = 0, saw_done = 0;
        logic [9:0] prev = '0;
        for (int i = 0; i < HALF; i++) begin
            int l = dval(v, i), h = dval(v, HALF + i);
            if (l != 0 || h != 0) begin
                eo[n] = 1; ed[n] = bidx(h, l); es[n] = 8; n++;
            end
            eo[n] = 2; ed[n] = 8; es[n] = 8; n++;
        end
        for (int j = 0; j < 12; j++) begin
            eo[n] = EP_O[j]; ed[n] = EP_D[j]; es[n] = EP_S[j]; n++;
        end
        for (int j = 0; j < HALF; j++) begin
            eo[n] = 2; ed[n] = 6; es[n] = 6; n++;
        end
        eo[n] = 1; ed[n] = 4; es[n] = 6; n++;
        for (int i = 0; i < NDIG; i++) ev += longint'(dval(v, i)) * (longint'(1) << i);
        em = ((ev % (PM - 1)) + (PM - 1)) % (PM - 1);
        for (int r = 0; r < 8; r++) rf[r] = 1;
        rf[8] = XB;

        @(negedge clk);
        exp_digits = v;
        start = 1'b1;
        while (1) begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
            if (inject && cyc == 6) begin
                start = 1'b1;
                exp_digits = ~v;
            end
            if (pend && !(cmd_valid && {cmd_op, cmd_dst, cmd_src} == prev)) stall_err++;
            if (done) begin
                saw_done = 1;
                check(!busy, "R8 busy low with done", longint'(busy), 0);
                break;
            end
            if (cyc > 3000) begin
                check(0, "watchdog run hung", cyc, n);
                break;
            end
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            cmd_ready = (rmode != 0) ? lf[0] : 1'b1;
            if (cmd_valid && cmd_ready) begin
                if (got < n) begin
                    if (int'(cmd_op) != eo[got] || int'(cmd_dst) != ed[got] || int'(cmd_src) != es[got]) begin
                        if (seq_err == 0) begin
                            bad_at = got; act_o = int'(cmd_op); act_d = int'(cmd_dst); act_s = int'(cmd_src);
                        end
                        seq_err++;
                    end
                end
                if (cmd_dst <= 4'd8 && cmd_src <= 4'd8) begin
                    case (cmd_op)
                        2'b01:   rf[cmd_dst] = (rf[cmd_dst] * rf[cmd_src]) % PM;
                        2'b10:   rf[cmd_dst] = (rf[cmd_src] * rf[cmd_src]) % PM;
                        2'b11:   rf[cmd_dst] = powmod(rf[cmd_src], PM - 2);
                        default: ;
                    endcase
                end
                got++;
            end
            pend = cmd_valid && !cmd_ready;
            prev = {cmd_op, cmd_dst, cmd_src};
        end
        check(saw_done, "R8 done pulse seen", longint'(saw_done), 1);
        check(got == n, "R9 command count", got, n);
        if (seq_err != 0)
            $display("  mismatch at %0d: op=%0d dst=%0d src=%0d vs op=%0d dst=%0d src=%0d",
                     bad_at, act_o, act_d, act_s, eo[bad_at], ed[bad_at], es[bad_at]);
        check(seq_err == 0, inject ? "R2 start while busy ignored" : "R3 R4 R5 command sequence",
              seq_err, 0);
        check(stall_err == 0, "R7 hold while not ready", stall_err, 0);
        check(rf[4] == powmod(XB, em), "R6 result x^e in reg 4", rf[4], powmod(XB, em));
        @(negedge clk);
        check(!done, "R8 done lasts one cycle", longint'(done), 0);
        cmd_ready = 1'b1;
    endtask

    initial begin
        total = 0; bad = 0; lf = 8'hA5;
        rst_n = 1'b0; start = 1'b0; cmd_ready = 1'b1; exp_digits = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !cmd_valid, "R1 reset state", {busy, done, cmd_valid}, 0);

        for (int t = 0; t < NV; t++) run_vec(VEC[t], RMODE[t], 1'b0);

        // R2: a second start in mid-run must not disturb the latched exponent.
        run_vec(VEC[3], 1, 1'b1);

        // R1: reset in the middle of a run returns the block to idle.
        @(negedge clk);
        exp_digits = VEC[1];
        start = 1'b1;
        cmd_ready = 1'b0;
        repeat (4) @(negedge clk);
        start = 1'b0;
        check(busy, "R1 run in progress before reset", longint'(busy), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check(!busy && !cmd_valid && !done, "R1 reset mid-run", {busy, done, cmd_valid}, 0);
        rst_n = 1'b1;
        cmd_ready = 1'b1;
        @(negedge clk);
        check(!busy && !cmd_valid, "R1 idle after reset", {busy, cmd_valid}, 0);
        run_vec(VEC[5], 0, 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule